// File: doc/BRIEF.md
# Data Address Translation Unit

This unit turns the virtual address of a load or store into a 44-bit physical address. It also reports any fault that the access raises. A request takes one of four routes, checked in this order. The first is physical pass-through, taken when the request is marked physical. The second is rejection of a malformed (non-canonical) virtual address. The third is a direct superpage map, which only kernel mode may use. The last is a search of a small fully associative translation buffer, keyed by virtual page number and address-space number.

A buffer hit is checked against per-mode read and write enables and against two page bits: trap-on-read and trap-on-write. Each faulting access returns a fault type and a five-bit status word that says why it failed. Six counters record activity, split by direction: lookups, misses and violations, each kept separately for loads and stores. The buffer is loaded through a plain write port that names the entry to replace. The request and response sides have no handshake. A request in one cycle gives a registered response in the next.

Top module: `dxlate_unit`

## Requirements
- R1: In the cycle after reset, the response-valid output, the physical address, the fault type (0) and the status word are zero, and all six counters read zero.
- R2: A request produces its response exactly one clock edge later, with rsp_valid high for that one cycle. The physical address reads zero whenever the fault type is not none.
- R3: A request marked physical returns virtual address bits 43:0 unchanged, with fault type none (0) and status 0. It changes no counter, even when its upper bits are malformed.
- R4: The superpage route is taken when sp_en bit 1 is set and virtual bits 42:41 equal 2'b10. In kernel mode (mode 0) the address is virtual bits 43:0, with bits 43:40 forced to all ones if bit 39 or bit 40 is set, and forced to zero otherwise.
- R5: A superpage access outside kernel mode gets fault type protection (1). Its status has the violation bit (bit 1), plus the write bit (bit 0) for stores. It counts one violation of its direction.
- R6: A non-physical address whose bits 63:43 do not all equal bit 42 gets fault type protection (1) before any other check. Its status is the violation bit plus the write bit for stores. It counts a violation but no lookup.
- R7: A buffer miss sets status bit 4, plus the write bit for stores. The fault type is page-table miss (4) when the page-table-entry flag is set, and plain miss (3) otherwise. It counts one lookup and one miss of its direction.
- R8: A hit needs a valid entry whose page number equals virtual bits 42:13 and whose address-space number equals the request's. The physical address is then the frame number shifted left by 13, ORed with virtual bits 12:0.
- R9: A store hitting a page whose write enable for the current mode is clear gets fault type generic (2). Its status is the write and violation bits, plus the trap-on-write bit (bit 3) if that page bit is set. It counts a store violation.
- R10: A permitted store to a page with trap-on-write set gets fault type generic (2) and status write plus trap-on-write. It counts a store violation.
- R11: A load hitting a page whose read enable for the current mode is clear gets fault type protection (1). Its status is the violation bit, plus trap-on-read (bit 2) if that page bit is set. It counts a load violation.
- R12: A permitted load to a page with trap-on-read set gets fault type generic (2) with only bit 2 in the status. It counts a load violation.
- R13: The lookup counters count only requests that take the buffer route (hit or miss). Superpage, physical and malformed-address requests leave them unchanged, and no counter moves without a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request this cycle |
| req_va | input | 64 | Virtual address |
| req_write | input | 1 | 1 = store, 0 = load |
| req_phys | input | 1 | Treat the address as physical |
| req_pte_acc | input | 1 | Access is a page-table-entry fetch |
| req_mode | input | 2 | Current mode, 0 = kernel, 3 = user |
| req_sp_en | input | 2 | Superpage enable field, bit 1 used |
| req_asn | input | 8 | Address-space number |
| fill_en | input | 1 | Write one buffer entry |
| fill_idx | input | IDX_W | Entry to overwrite |
| fill_vpn | input | 30 | Virtual page number |
| fill_asn | input | 8 | Address-space number of entry |
| fill_pfn | input | 31 | Physical frame number |
| fill_rd_en | input | 4 | Read enable, one bit per mode |
| fill_wr_en | input | 4 | Write enable, one bit per mode |
| fill_trap_rd | input | 1 | Trap-on-read page bit |
| fill_trap_wr | input | 1 | Trap-on-write page bit |
| rsp_valid | output | 1 | Response valid |
| rsp_pa | output | 44 | Physical address |
| rsp_fault | output | 3 | Fault type: 0 none, 1 protection, 2 generic, 3 miss, 4 page-table miss |
| rsp_stat | output | 5 | Status: 0 write, 1 violation, 2 trap-on-read, 3 trap-on-write, 4 miss |
| cnt_rd_acc | output | CNT_W | Load lookups |
| cnt_wr_acc | output | CNT_W | Store lookups |
| cnt_rd_miss | output | CNT_W | Load misses |
| cnt_wr_miss | output | CNT_W | Store misses |
| cnt_rd_viol | output | CNT_W | Load violations |
| cnt_wr_viol | output | CNT_W | Store violations |

## Verification
The hardest states to reach are those where the checks must run in a fixed order. Examples are a store that both lacks permission and hits a trap-on-write page, or a superpage-shaped address that falls through to the buffer because its enable bit is clear. The bench loads entries through the fill port with chosen enable masks and trap bits. It then sends the same address in several modes and directions, so that each branch of the permission logic is reached on its own. It also sends malformed addresses with and without the physical flag, to show that malformed-address rejection comes before everything except pass-through.

// File: rtl/dxl_pkg.sv
package dxl_pkg;

    localparam int VA_W     = 64;
    localparam int PA_W     = 44;
    localparam int PG_SHIFT = 13;
    localparam int VPN_W    = 43 - PG_SHIFT;
    localparam int PFN_W    = PA_W - PG_SHIFT;
    localparam int ASN_W    = 8;
    localparam int MODES    = 4;
    localparam int MODE_W   = $clog2(MODES);
    localparam int STAT_W   = 5;

    localparam int ST_WR    = 0;
    localparam int ST_VIOL  = 1;
    localparam int ST_TRD   = 2;
    localparam int ST_TWR   = 3;
    localparam int ST_MISS  = 4;

    localparam logic [MODE_W-1:0] MODE_KERNEL = '0;
    localparam logic [1:0]        SP_REGION   = 2'b10;

    typedef enum logic [2:0] {
        XF_NONE   = 3'd0,
        XF_PROT   = 3'd1,
        XF_GEN    = 3'd2,
        XF_MISS   = 3'd3,
        XF_PTMISS = 3'd4
    } xl_fault_e;

    typedef enum logic [1:0] {
        RT_PHYS,
        RT_BADVA,
        RT_SUPER,
        RT_LOOKUP
    } xl_route_e;

    typedef struct packed {
        logic              valid;
        logic [VPN_W-1:0]  vpn;
        logic [ASN_W-1:0]  asn;
        logic [PFN_W-1:0]  pfn;
        logic [MODES-1:0]  rd_en;
        logic [MODES-1:0]  wr_en;
        logic              trap_rd;
        logic              trap_wr;
    } xl_entry_t;

    typedef struct packed {
        logic [PA_W-1:0]   pa;
        xl_fault_e         fault;
        logic [STAT_W-1:0] stat;
    } xl_result_t;

    function automatic logic va_canonical(input logic [VA_W-1:0] va);
        logic [VA_W-44:0] upper;
        upper = va[VA_W-1:43];
        return va[42] ? (&upper) : ~(|upper);
    endfunction

    function automatic logic [PA_W-1:0] sp_extend(input logic [PA_W-1:0] raw);
        logic [PA_W-1:0] pa;
        pa = raw;
        if (raw[39] || raw[40])
            pa[PA_W-1:40] = '1;
        else
            pa[PA_W-1:40] = '0;
        return pa;
    endfunction

endpackage

// File: rtl/dxl_tbuf.sv
module dxl_tbuf
    import dxl_pkg::*;
#(
    parameter int ENTRIES = 8,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fill_en,
    input  logic [IDX_W-1:0]  fill_idx,
    input  xl_entry_t         fill_ent,
    input  logic [VPN_W-1:0]  look_vpn,
    input  logic [ASN_W-1:0]  look_asn,
    output logic              look_hit,
    output xl_entry_t         look_ent
);

    xl_entry_t          ents [ENTRIES];
    logic [ENTRIES-1:0] match;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
        always_ff @(posedge clk) begin
            if (rst)
                ents[g] <= '0;
            else if (fill_en && fill_idx == IDX_W'(g))
                ents[g] <= fill_ent;
        end
        assign match[g] = ents[g].valid && ents[g].vpn == look_vpn
                          && ents[g].asn == look_asn;
    end

    // lowest-numbered matching entry wins
    always_comb begin
        look_hit = |match;
        look_ent = '0;
        for (int i = ENTRIES - 1; i >= 0; i--)
            if (match[i]) look_ent = ents[i];
    end

    a_r8_fill_visible: assert property (@(posedge clk) disable iff (rst)
        fill_en && fill_ent.valid |=> ents[$past(fill_idx)].valid)
        else $error("filled entry not valid");

endmodule

// File: rtl/dxl_classify.sv
module dxl_classify
    import dxl_pkg::*;
(
    input  logic [VA_W-1:0]   va,
    input  logic              write,
    input  logic              phys,
    input  logic              pte_acc,
    input  logic [MODE_W-1:0] mode,
    input  logic [1:0]        sp_en,
    input  logic              hit,
    input  xl_entry_t         ent,
    output xl_result_t        res,
    output xl_route_e         route
);

    logic [STAT_W-1:0] wbit;
    assign wbit = write ? STAT_W'(1 << ST_WR) : '0;

    always_comb begin
        res   = '0;
        route = RT_LOOKUP;
        if (phys) begin
            route  = RT_PHYS;
            res.pa = va[PA_W-1:0];
        end else if (!va_canonical(va)) begin
            route     = RT_BADVA;
            res.fault = XF_PROT;
            res.stat  = wbit | STAT_W'(1 << ST_VIOL);
        end else if (sp_en[1] && va[42:41] == SP_REGION) begin
            route = RT_SUPER;
            if (mode != MODE_KERNEL) begin
                res.fault = XF_PROT;
                res.stat  = wbit | STAT_W'(1 << ST_VIOL);
            end else begin
                res.pa = sp_extend(va[PA_W-1:0]);
            end
        end else if (!hit) begin
            res.fault = pte_acc ? XF_PTMISS : XF_MISS;
            res.stat  = wbit | STAT_W'(1 << ST_MISS);
        end else if (write) begin
            if (!ent.wr_en[mode]) begin
                res.fault = XF_GEN;
                res.stat  = wbit | STAT_W'(1 << ST_VIOL)
                          | (ent.trap_wr ? STAT_W'(1 << ST_TWR) : '0);
            end else if (ent.trap_wr) begin
                res.fault = XF_GEN;
                res.stat  = wbit | STAT_W'(1 << ST_TWR);
            end else begin
                res.pa = {ent.pfn, va[PG_SHIFT-1:0]};
            end
        end else begin
            if (!ent.rd_en[mode]) begin
                res.fault = XF_PROT;
                res.stat  = STAT_W'(1 << ST_VIOL)
                          | (ent.trap_rd ? STAT_W'(1 << ST_TRD) : '0);
            end else if (ent.trap_rd) begin
                res.fault = XF_GEN;
                res.stat  = STAT_W'(1 << ST_TRD);
            end else begin
                res.pa = {ent.pfn, va[PG_SHIFT-1:0]};
            end
        end
    end

endmodule

// File: rtl/dxl_counters.sv
module dxl_counters
    import dxl_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fire,
    input  logic              write,
    input  xl_route_e         route,
    input  xl_result_t        res,
    output logic [CNT_W-1:0]  acc  [2],
    output logic [CNT_W-1:0]  miss [2],
    output logic [CNT_W-1:0]  viol [2]
);

    logic is_lookup, is_miss, is_viol;
    assign is_lookup = route == RT_LOOKUP;
    assign is_miss   = res.stat[ST_MISS];
    assign is_viol   = res.fault != XF_NONE && !is_miss;

    // index 0 counts loads, index 1 counts stores
    for (genvar d = 0; d < 2; d++) begin : g_dir
        logic sel;
        assign sel = fire && (write == d[0]);
        always_ff @(posedge clk) begin
            if (rst) begin
                acc[d]  <= '0;
                miss[d] <= '0;
                viol[d] <= '0;
            end else if (sel) begin
                if (is_lookup) acc[d]  <= acc[d] + 1'b1;
                if (is_miss)   miss[d] <= miss[d] + 1'b1;
                if (is_viol)   viol[d] <= viol[d] + 1'b1;
            end
        end
    end

    a_r13_miss_is_lookup: assert property (@(posedge clk) disable iff (rst)
        fire && is_miss |-> is_lookup)
        else $error("miss outside lookup route");

endmodule

// File: rtl/dxlate_unit.sv
module dxlate_unit
    import dxl_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int CNT_W   = 16,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid,
    input  logic [63:0]          req_va,
    input  logic                 req_write,
    input  logic                 req_phys,
    input  logic                 req_pte_acc,
    input  logic [1:0]           req_mode,
    input  logic [1:0]           req_sp_en,
    input  logic [7:0]           req_asn,
    input  logic                 fill_en,
    input  logic [IDX_W-1:0]     fill_idx,
    input  logic [29:0]          fill_vpn,
    input  logic [7:0]           fill_asn,
    input  logic [30:0]          fill_pfn,
    input  logic [3:0]           fill_rd_en,
    input  logic [3:0]           fill_wr_en,
    input  logic                 fill_trap_rd,
    input  logic                 fill_trap_wr,
    output logic                 rsp_valid,
    output logic [43:0]          rsp_pa,
    output logic [2:0]           rsp_fault,
    output logic [4:0]           rsp_stat,
    output logic [CNT_W-1:0]     cnt_rd_acc,
    output logic [CNT_W-1:0]     cnt_wr_acc,
    output logic [CNT_W-1:0]     cnt_rd_miss,
    output logic [CNT_W-1:0]     cnt_wr_miss,
    output logic [CNT_W-1:0]     cnt_rd_viol,
    output logic [CNT_W-1:0]     cnt_wr_viol
);

    xl_entry_t  fill_ent, hit_ent;
    logic       hit;
    xl_result_t res, res_q;
    xl_route_e  route;
    logic [CNT_W-1:0] acc [2];
    logic [CNT_W-1:0] miss [2];
    logic [CNT_W-1:0] viol [2];

    always_comb begin
        fill_ent         = '0;
        fill_ent.valid   = 1'b1;
        fill_ent.vpn     = fill_vpn;
        fill_ent.asn     = fill_asn;
        fill_ent.pfn     = fill_pfn;
        fill_ent.rd_en   = fill_rd_en;
        fill_ent.wr_en   = fill_wr_en;
        fill_ent.trap_rd = fill_trap_rd;
        fill_ent.trap_wr = fill_trap_wr;
    end

    dxl_tbuf #(.ENTRIES(ENTRIES)) u_tbuf (
        .clk      (clk),
        .rst      (rst),
        .fill_en  (fill_en),
        .fill_idx (fill_idx),
        .fill_ent (fill_ent),
        .look_vpn (req_va[42:PG_SHIFT]),
        .look_asn (req_asn),
        .look_hit (hit),
        .look_ent (hit_ent)
    );

    dxl_classify u_cls (
        .va      (req_va),
        .write   (req_write),
        .phys    (req_phys),
        .pte_acc (req_pte_acc),
        .mode    (req_mode),
        .sp_en   (req_sp_en),
        .hit     (hit),
        .ent     (hit_ent),
        .res     (res),
        .route   (route)
    );

    dxl_counters #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst   (rst),
        .fire  (req_valid),
        .write (req_write),
        .route (route),
        .res   (res),
        .acc   (acc),
        .miss  (miss),
        .viol  (viol)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            res_q     <= '0;
        end else begin
            rsp_valid <= req_valid;
            if (req_valid) res_q <= res;
        end
    end

    assign rsp_pa      = rsp_valid ? res_q.pa : '0;
    assign rsp_fault   = rsp_valid ? res_q.fault : XF_NONE;
    assign rsp_stat    = rsp_valid ? res_q.stat : '0;
    assign cnt_rd_acc  = acc[0];
    assign cnt_wr_acc  = acc[1];
    assign cnt_rd_miss = miss[0];
    assign cnt_wr_miss = miss[1];
    assign cnt_rd_viol = viol[0];
    assign cnt_wr_viol = viol[1];

    a_r2_one_cycle: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid)
        else $error("response missing");
    a_r2_no_spurious: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid)
        else $error("spurious response");
    a_r2_fault_pa_zero: assert property (@(posedge clk) disable iff (rst)
        rsp_valid && rsp_fault != XF_NONE |-> rsp_pa == '0)
        else $error("address on fault");
    a_r7_miss_type: assert property (@(posedge clk) disable iff (rst)
        rsp_valid && rsp_stat[ST_MISS] |-> rsp_fault == XF_MISS || rsp_fault == XF_PTMISS)
        else $error("miss bit with wrong type");
    a_r13_idle_stable: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> $stable(cnt_rd_acc) && $stable(cnt_wr_acc)
                       && $stable(cnt_rd_viol) && $stable(cnt_wr_viol))
        else $error("counter moved while idle");
    a_r5_super_user: assert property (@(posedge clk) disable iff (rst)
        req_valid && !req_phys && req_sp_en[1] && req_va[42:41] == SP_REGION
        && va_canonical(req_va) && req_mode != MODE_KERNEL
        |=> rsp_fault == XF_PROT && rsp_stat[ST_VIOL])
        else $error("user superpage not rejected");

endmodule

// File: tb/dxlate_unit_test.sv
`timescale 1ns/1ps
module dxlate_unit_test;
    localparam int CNT_W = 16;

    logic clk = 0, rst = 1;
    logic req_valid = 0, req_write = 0, req_phys = 0, req_pte_acc = 0;
    logic [63:0] req_va = 0;
    logic [1:0] req_mode = 0, req_sp_en = 2'b10;
    logic [7:0] req_asn = 5;
    logic fill_en = 0;
    logic [2:0] fill_idx = 0;
    logic [29:0] fill_vpn = 0;
    logic [7:0] fill_asn = 0;
    logic [30:0] fill_pfn = 0;
    logic [3:0] fill_rd_en = 0, fill_wr_en = 0;
    logic fill_trap_rd = 0, fill_trap_wr = 0;
    logic rsp_valid;
    logic [43:0] rsp_pa;
    logic [2:0] rsp_fault;
    logic [4:0] rsp_stat;
    logic [CNT_W-1:0] c_ra, c_wa, c_rm, c_wm, c_rv, c_wv;

    int tests = 0, fails = 0;
    int e_ra = 0, e_wa = 0, e_rm = 0, e_wm = 0, e_rv = 0, e_wv = 0;

    always #5 clk = ~clk;

    dxlate_unit uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_va(req_va),
        .req_write(req_write), .req_phys(req_phys), .req_pte_acc(req_pte_acc),
        .req_mode(req_mode), .req_sp_en(req_sp_en), .req_asn(req_asn),
        .fill_en(fill_en), .fill_idx(fill_idx), .fill_vpn(fill_vpn),
        .fill_asn(fill_asn), .fill_pfn(fill_pfn), .fill_rd_en(fill_rd_en),
        .fill_wr_en(fill_wr_en), .fill_trap_rd(fill_trap_rd),
        .fill_trap_wr(fill_trap_wr), .rsp_valid(rsp_valid), .rsp_pa(rsp_pa),
        .rsp_fault(rsp_fault), .rsp_stat(rsp_stat),
        .cnt_rd_acc(c_ra), .cnt_wr_acc(c_wa), .cnt_rd_miss(c_rm),
        .cnt_wr_miss(c_wm), .cnt_rd_viol(c_rv), .cnt_wr_viol(c_wv));

    task automatic chk(string req, string what, longint act, longint exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic fill(input int idx, input logic [29:0] vpn, input logic [30:0] pfn,
                        input logic [3:0] rd, input logic [3:0] wr,
                        input logic trd, input logic twr);
        @(negedge clk);
        fill_en = 1; fill_idx = 3'(idx); fill_vpn = vpn; fill_asn = 8'd5;
        fill_pfn = pfn; fill_rd_en = rd; fill_wr_en = wr;
        fill_trap_rd = trd; fill_trap_wr = twr;
        @(negedge clk);
        fill_en = 0;
    endtask

    // drive one request, sample the registered response and counters
    task automatic xlate(string req, input logic [63:0] va, input logic wr,
                         input logic [1:0] mode, input logic phys, input logic pte,
                         input logic lookup, input logic [43:0] epa,
                         input int efault, input logic [4:0] estat);
        @(negedge clk);
        req_valid = 1; req_va = va; req_write = wr; req_mode = mode;
        req_phys = phys; req_pte_acc = pte;
        @(negedge clk);
        req_valid = 0;
        chk(req, "valid", longint'(rsp_valid), 1);
        chk(req, "pa", longint'(rsp_pa), longint'(epa));
        chk(req, "fault", longint'(rsp_fault), longint'(efault));
        chk(req, "stat", longint'(rsp_stat), longint'(estat));
        if (lookup) begin if (wr) e_wa++; else e_ra++; end
        if (estat[4]) begin if (wr) e_wm++; else e_rm++; end
        else if (efault != 0) begin if (wr) e_wv++; else e_rv++; end
        chk(req, "cnt_rd_acc", longint'(c_ra), longint'(e_ra));
        chk(req, "cnt_wr_acc", longint'(c_wa), longint'(e_wa));
        chk(req, "cnt_rd_miss", longint'(c_rm), longint'(e_rm));
        chk(req, "cnt_wr_miss", longint'(c_wm), longint'(e_wm));
        chk(req, "cnt_rd_viol", longint'(c_rv), longint'(e_rv));
        chk(req, "cnt_wr_viol", longint'(c_wv), longint'(e_wv));
        @(negedge clk);
        chk(req, "valid drops (R2)", longint'(rsp_valid), 0);
    endtask

    task automatic t_reset;
        chk("R1", "valid", longint'(rsp_valid), 0);
        chk("R1", "pa", longint'(rsp_pa), 0);
        chk("R1", "fault", longint'(rsp_fault), 0);
        chk("R1", "stat", longint'(rsp_stat), 0);
        chk("R1", "counters", longint'(c_ra | c_wa | c_rm | c_wm | c_rv | c_wv), 0);
    endtask

    task automatic t_phys;
        xlate("R3", 64'h0000_0123_4567_89AB, 0, 2'd3, 1, 0, 0, 44'h123_4567_89AB, 0, 5'h00);
        xlate("R3", 64'h0000_0400_0000_0000, 1, 2'd3, 1, 0, 0, 44'h400_0000_0000, 0, 5'h00);
    endtask

    task automatic t_super;
        req_sp_en = 2'b10;
        xlate("R4", 64'hFFFF_FC12_3456_7890, 0, 2'd0, 0, 0, 0, 44'h012_3456_7890, 0, 5'h00);
        xlate("R4", 64'hFFFF_FC80_0000_1000, 1, 2'd0, 0, 0, 0, 44'hF80_0000_1000, 0, 5'h00);
        xlate("R4", 64'hFFFF_FD00_0000_2000, 0, 2'd0, 0, 0, 0, 44'hF00_0000_2000, 0, 5'h00);
        xlate("R5", 64'hFFFF_FC12_3456_7890, 0, 2'd3, 0, 0, 0, 44'h0, 1, 5'h02);
        xlate("R5", 64'hFFFF_FC12_3456_7890, 1, 2'd2, 0, 0, 0, 44'h0, 1, 5'h03);
        // enable bit clear: falls through to buffer, misses (R13)
        req_sp_en = 2'b01;
        xlate("R13", 64'hFFFF_FC12_3456_7890, 0, 2'd0, 0, 0, 1, 44'h0, 3, 5'h10);
        req_sp_en = 2'b10;
    endtask

    task automatic t_badva;
        xlate("R6", 64'h0000_0400_0000_0000, 1, 2'd0, 0, 0, 0, 44'h0, 1, 5'h03);
        xlate("R6", 64'h8000_0000_0004_6ABC, 0, 2'd0, 0, 0, 0, 44'h0, 1, 5'h02);
    endtask

    task automatic t_hit;
        xlate("R8", 64'h0000_0000_0004_6ABC, 0, 2'd0, 0, 0, 1, 44'h000_0246_8ABC, 0, 5'h00);
        xlate("R8", 64'h0000_0000_0004_6001, 1, 2'd3, 0, 0, 1, 44'h000_0246_8001, 0, 5'h00);
    endtask

    task automatic t_miss;
        req_asn = 8'd6;
        xlate("R7", 64'h0000_0000_0004_6ABC, 0, 2'd0, 0, 0, 1, 44'h0, 3, 5'h10);
        xlate("R7", 64'h0000_0000_0004_6ABC, 1, 2'd0, 0, 1, 1, 44'h0, 4, 5'h11);
        req_asn = 8'd5;
        xlate("R7", 64'h0000_0000_0010_0000, 0, 2'd0, 0, 1, 1, 44'h0, 4, 5'h10);
    endtask

    task automatic t_perm;
        xlate("R9",  64'h0000_0000_0008_0010, 1, 2'd3, 0, 0, 1, 44'h0, 2, 5'h0B);
        xlate("R11", 64'h0000_0000_0008_0010, 0, 2'd3, 0, 0, 1, 44'h0, 1, 5'h06);
        xlate("R10", 64'h0000_0000_0008_2020, 1, 2'd0, 0, 0, 1, 44'h0, 2, 5'h09);
        xlate("R12", 64'h0000_0000_0008_2020, 0, 2'd0, 0, 0, 1, 44'h0, 2, 5'h04);
        xlate("R9",  64'h0000_0000_0008_6000, 1, 2'd1, 0, 0, 1, 44'h0, 2, 5'h03);
        xlate("R11", 64'h0000_0000_0008_6000, 0, 2'd1, 0, 0, 1, 44'h0, 1, 5'h02);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        @(negedge clk);
        t_reset();
        fill(0, 30'h23, 31'h1234, 4'hF, 4'hF, 0, 0);
        fill(1, 30'h40, 31'h55,   4'h1, 4'h1, 1, 1);
        fill(2, 30'h41, 31'h66,   4'hF, 4'hF, 1, 1);
        fill(3, 30'h43, 31'h77,   4'h1, 4'h1, 0, 0);
        t_phys();
        t_super();
        t_badva();
        t_hit();
        t_miss();
        t_perm();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #500000;
        tests++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule